// File: doc/BRIEF.md
# Two-Page I2C Byte Memory with Sampled Input Port

This block is the slave side of a two-wire serial bus in front of a small byte memory made of two 256-byte halves. A transaction starts with a device byte. Its upper six bits must equal a fixed device identifier. The next bit picks the half, and the last bit gives the direction. A write carries a byte pointer followed by any number of data bytes. The pointer advances after every byte and wraps inside the chosen half. A read streams bytes from the current pointer until the master declines a byte.

Once a write that stored data has ended with STOP, the block imitates a nonvolatile commit. For a fixed number of clocks it declines its own device byte. The master polls with repeated STARTs until the device byte is acknowledged again. Two pointer values in the lower half have special meaning. One is a mode byte. The other returns a live sample of an 8-bit input port. Each sample is taken in the middle of the byte sent before the one that carries it. A direct-port mode returns port samples for every byte read.

Top module: `i2c_paged_mem`

## Requirements
- R1: A device byte is acknowledged (SDA low in the ninth clock) only when its bits 7..2 equal DEV_ID. Bit 1 is the half select and bit 0 is the direction (1 = read). Any other device byte is not acknowledged, and the block then stays silent until the next START or STOP.
- R2: In a write, the first byte after the device byte loads the pointer. Each following byte is stored at the pointer and acknowledged, and the pointer then increments, wrapping from FFh to 00h within the same half.
- R3: The half select of the last accepted write device byte chooses the half used by both writes and reads. The same pointer value in the two halves holds independent data.
- R4: A read returns the byte at the pointer and then increments the pointer, for as long as the master acknowledges. After a master NACK the block releases SDA and drives nothing until the next START or STOP.
- R5: A STOP that ends a write in which at least one data byte was stored starts a busy period of PROG_CYCLES clocks. During that period every device byte is declined and the bytes that follow it are ignored. A write that only loaded the pointer starts no busy period.
- R6: Pointer 7Ah in the lower half is a mode byte. It is 00h after reset, reads back what was written, and is not stored in the array. Pointer 7Ah in the upper half is ordinary memory.
- R7: With mode bit 7 clear, reading pointer 7Bh of the lower half returns the port value sampled at the fourth SCL rise of the byte sent just before it. That earlier byte is the 7Ah byte, or the device byte when the read starts at 7Bh.
- R8: With mode bit 7 set, every read byte is a port sample. The first byte carries the sample taken during the device byte of the previous accepted transaction, and each later byte carries the sample taken during the byte before it.
- R9: A START in any state, including in the middle of a byte, restarts device-byte reception with a cleared bit count. A STOP in any state returns the block to idle.
- R10: SDA is open-drain: the block only enables a low drive. The enable changes only while SCL is low, and it is off during reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Serial clock line as seen on the bus |
| sda_i | input | 1 | Serial data line as seen on the bus |
| sda_oe_o | output | 1 | Pull SDA low when 1; release when 0 |
| port_i | input | 8 | General-purpose input port |

## Verification
Two functions can fall in the same clock edge. The mid-byte port capture runs on the SCL rise that the byte shifter also uses. A stored sample is then consumed by the byte load on a later SCL fall, so a port value can be overwritten in the same cycle that an older value is being handed out. The bench changes the port value at every byte boundary with a distinct pattern. It accepts a returned byte only if it equals the value held during the preceding byte, never the value held during its own byte. A second overlap is a STOP that ends a data write, which must start the busy period in the same edge that returns the state machine to idle. This is judged by a device byte sent right after that STOP being declined.

// File: rtl/i2cpm_pkg.sv
`timescale 1ns/1ps
package i2cpm_pkg;
    localparam int          BYTE_W    = 8;
    localparam logic [7:0]  MODE_PTR  = 8'h7A;
    localparam logic [7:0]  PORT_PTR  = 8'h7B;
    localparam int          MODE_DIR  = 7;     // mode bit selecting direct-port reads
    localparam logic [3:0]  SMP_RISE  = 4'd3;  // count value at the fourth SCL rise

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DEV,
        ST_WPTR,
        ST_WDAT,
        ST_ACK,
        ST_RDAT,
        ST_RACK,
        ST_WAIT
    } st_e;
endpackage

// File: rtl/i2cpm_pin_sync.sv
`timescale 1ns/1ps
module i2cpm_pin_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [2:0] scl_q, sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= '1;
            sda_q <= '1;
        end else begin
            scl_q <= {scl_q[1:0], scl_i};
            sda_q <= {sda_q[1:0], sda_i};
        end
    end

    assign scl_s     = scl_q[1];
    assign sda_s     = sda_q[1];
    assign scl_rise  = scl_q[1] & ~scl_q[2];
    assign scl_fall  = ~scl_q[1] & scl_q[2];
    assign start_det = scl_q[1] & scl_q[2] & sda_q[2] & ~sda_q[1];
    assign stop_det  = scl_q[1] & scl_q[2] & ~sda_q[2] & sda_q[1];
endmodule

// File: rtl/i2cpm_prog_timer.sv
`timescale 1ns/1ps
module i2cpm_prog_timer #(
    parameter int CYCLES = 5000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic go,
    output logic busy
);
    localparam int CW = $clog2(CYCLES + 1);
    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (go)
            cnt_d = CW'(CYCLES);
        else if (cnt_q != '0)
            cnt_d = cnt_q - CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy = (cnt_q != '0);
endmodule

// File: rtl/i2cpm_store.sv
`timescale 1ns/1ps
module i2cpm_store #(
    parameter int AW = 9,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/i2c_paged_mem.sv
`timescale 1ns/1ps
module i2c_paged_mem
    import i2cpm_pkg::*;
#(
    parameter logic [5:0] DEV_ID      = 6'b101000,
    parameter int         PROG_CYCLES = 5000,
    parameter int         ADDR_W      = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        scl_i,
    input  logic        sda_i,
    output logic        sda_oe_o,
    input  logic [7:0]  port_i
);
    localparam int MEM_AW = ADDR_W + 1;
    localparam logic [ADDR_W-1:0] MODE_A = ADDR_W'(MODE_PTR);
    localparam logic [ADDR_W-1:0] PORT_A = ADDR_W'(PORT_PTR);

    typedef struct packed {
        st_e               st;
        st_e               nxt;
        logic [3:0]        cnt;
        logic [7:0]        sh;
        logic [7:0]        tx;
        logic              oe;
        logic [ADDR_W-1:0] ptr;
        logic              page;
        logic              dirty;
        logic [7:0]        mode;
        logic [7:0]        cur_smp;
        logic [7:0]        hdr_smp;
        logic [7:0]        first_smp;
        logic              rd_first;
    } fsm_t;

    fsm_t d, q;

    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic busy, prog_go, mem_we;
    logic [7:0] mem_rd, rd_byte;
    st_e        cur_st;
    logic [3:0] bit_cnt;

    i2cpm_pin_sync u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2cpm_prog_timer #(.CYCLES(PROG_CYCLES)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .go    (prog_go),
        .busy  (busy)
    );

    i2cpm_store #(.AW(MEM_AW), .DW(BYTE_W)) u_store (
        .clk   (clk),
        .we    (mem_we),
        .waddr ({q.page, q.ptr}),
        .wdata (q.sh),
        .raddr ({q.page, q.ptr}),
        .rdata (mem_rd)
    );

    // byte presented for the next read slot
    always_comb begin
        if (q.mode[MODE_DIR])
            rd_byte = q.rd_first ? q.first_smp : q.cur_smp;
        else if (!q.page && q.ptr == PORT_A)
            rd_byte = q.cur_smp;
        else if (!q.page && q.ptr == MODE_A)
            rd_byte = q.mode;
        else
            rd_byte = mem_rd;
    end

    always_comb begin
        d       = q;
        mem_we  = 1'b0;
        prog_go = 1'b0;
        if (start_det) begin
            d.st  = ST_DEV;
            d.cnt = '0;
            d.oe  = 1'b0;
        end else if (stop_det) begin
            d.st    = ST_IDLE;
            d.cnt   = '0;
            d.oe    = 1'b0;
            prog_go = q.dirty;
            d.dirty = 1'b0;
        end else begin
            if (scl_rise && q.cnt == SMP_RISE &&
                (q.st == ST_DEV || q.st == ST_WPTR || q.st == ST_WDAT || q.st == ST_RDAT))
                d.cur_smp = port_i;
            case (q.st)
                ST_DEV, ST_WPTR, ST_WDAT: begin
                    if (scl_rise) begin
                        d.sh  = {q.sh[6:0], sda_s};
                        d.cnt = q.cnt + 4'd1;
                    end else if (scl_fall && q.cnt == 4'd8) begin
                        d.cnt = '0;
                        d.st  = ST_ACK;
                        if (q.st == ST_DEV) begin
                            if (q.sh[7:2] == DEV_ID && !busy) begin
                                d.oe        = 1'b1;
                                d.first_smp = q.hdr_smp;
                                d.hdr_smp   = q.cur_smp;
                                d.rd_first  = 1'b1;
                                if (q.sh[0]) begin
                                    d.nxt = ST_RDAT;
                                end else begin
                                    d.nxt  = ST_WPTR;
                                    d.page = q.sh[1];
                                end
                            end else begin
                                d.st = ST_WAIT;
                            end
                        end else if (q.st == ST_WPTR) begin
                            d.ptr = q.sh[ADDR_W-1:0];
                            d.oe  = 1'b1;
                            d.nxt = ST_WDAT;
                        end else begin
                            if (!q.page && q.ptr == MODE_A)
                                d.mode = q.sh;
                            else
                                mem_we = 1'b1;
                            d.ptr   = q.ptr + ADDR_W'(1);
                            d.dirty = 1'b1;
                            d.oe    = 1'b1;
                            d.nxt   = ST_WDAT;
                        end
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        d.oe  = 1'b0;
                        d.st  = q.nxt;
                        d.cnt = '0;
                        if (q.nxt == ST_RDAT) begin
                            d.tx       = rd_byte;
                            d.oe       = ~rd_byte[7];
                            d.ptr      = q.ptr + ADDR_W'(1);
                            d.rd_first = 1'b0;
                        end
                    end
                end
                ST_RDAT: begin
                    if (scl_fall) begin
                        d.cnt = q.cnt + 4'd1;
                        if (q.cnt == 4'd7) begin
                            d.st = ST_RACK;
                            d.oe = 1'b0;
                        end else begin
                            d.tx = {q.tx[6:0], 1'b0};
                            d.oe = ~q.tx[6];
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise) begin
                        if (sda_s) d.st = ST_WAIT;
                    end else if (scl_fall) begin
                        d.st       = ST_RDAT;
                        d.cnt      = '0;
                        d.tx       = rd_byte;
                        d.oe       = ~rd_byte[7];
                        d.ptr      = q.ptr + ADDR_W'(1);
                        d.rd_first = 1'b0;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sda_oe_o = q.oe;
    assign cur_st   = q.st;
    assign bit_cnt  = q.cnt;
endmodule

// File: rtl/i2cpm_checker.sv
`timescale 1ns/1ps
module i2cpm_checker
    import i2cpm_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       scl_s,
    input logic       sda_oe,
    input logic       busy,
    input logic       prog_go,
    input logic       start_det,
    input logic       stop_det,
    input st_e        st,
    input logic [3:0] bit_cnt
);
    AST_OE_ONLY_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_s && $past(scl_s)) |-> $stable(sda_oe)) else $error("oe moved while SCL high"); // R10

    AST_BUSY_AFTER_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
        prog_go |=> busy) else $error("commit did not raise busy"); // R5

    AST_NO_ACK_WHEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (st != ST_ACK)) else $error("acknowledge during busy"); // R5

    AST_START_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (st == ST_DEV && bit_cnt == 4'd0)) else $error("start not honoured"); // R9

    AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (st == ST_IDLE)) else $error("stop not honoured"); // R9

    AST_SILENT_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_WAIT) |-> !sda_oe) else $error("drive while waiting"); // R4
endmodule

bind i2c_paged_mem i2cpm_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_s     (scl_s),
    .sda_oe    (sda_oe_o),
    .busy      (busy),
    .prog_go   (prog_go),
    .start_det (start_det),
    .stop_det  (stop_det),
    .st        (cur_st),
    .bit_cnt   (bit_cnt)
);

// File: tb/i2c_paged_mem_test.sv
`timescale 1ns/1ps
module i2c_paged_mem_test;
    localparam logic [5:0] DEV = 6'b101000;
    localparam int H = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic [7:0] port_v = 8'h00;
    logic sda_oe;
    logic sda_line;
    int n_chk = 0;
    int n_bad = 0;
    int r10_bad = 0;
    logic prev_scl = 1'b1;
    logic prev_oe = 1'b0;
    logic [7:0] exp_mem [512];

    assign sda_line = sda_m & ~sda_oe;

    always #2 clk = ~clk;

    i2c_paged_mem #(.DEV_ID(DEV), .PROG_CYCLES(600)) uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_m),
        .sda_i    (sda_line),
        .sda_oe_o (sda_oe),
        .port_i   (port_v)
    );

    // R10 monitor: the enable must not change while the bus clock stays high
    always @(posedge clk) begin
        if (rst_n && scl_m && prev_scl && (sda_oe !== prev_oe)) r10_bad <= r10_bad + 1;
        prev_scl <= scl_m;
        prev_oe  <= sda_oe;
    end

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [7:0] dev(input logic pg, input logic rw);
        return {DEV, pg, rw};
    endfunction

    task automatic b_start();
        sda_m = 1'b1; scl_m = 1'b1; tick(H);
        sda_m = 1'b0; tick(H);
        scl_m = 1'b0; tick(2);
    endtask

    task automatic b_rstart();
        sda_m = 1'b1; tick(H);
        scl_m = 1'b1; tick(H);
        sda_m = 1'b0; tick(H);
        scl_m = 1'b0; tick(2);
    endtask

    task automatic b_stop();
        sda_m = 1'b0; tick(H);
        scl_m = 1'b1; tick(H);
        sda_m = 1'b1; tick(H);
    endtask

    task automatic send_bits(input logic [7:0] b, input int nb);
        for (int i = 7; i > 7 - nb; i--) begin
            sda_m = b[i]; tick(H);
            scl_m = 1'b1; tick(H);
            scl_m = 1'b0; tick(2);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output logic ack);
        send_bits(b, 8);
        sda_m = 1'b1; tick(H);
        scl_m = 1'b1; tick(H / 2);
        ack = ~sda_line;
        tick(H - H / 2);
        scl_m = 1'b0; tick(2);
    endtask

    task automatic recv_byte(output logic [7:0] b, input logic mack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = 1'b1; tick(H);
            scl_m = 1'b1; tick(H / 2);
            b[i] = sda_line;
            tick(H - H / 2);
            scl_m = 1'b0; tick(2);
        end
        sda_m = ~mack; tick(H);
        scl_m = 1'b1; tick(H);
        scl_m = 1'b0; tick(2);
        sda_m = 1'b1;
    endtask

    task automatic poll(input logic [7:0] pv, output int n);
        logic ack;
        port_v = pv;
        b_start();
        send_byte(dev(1'b0, 1'b0), ack);
        n = 1;
        while (!ack && n < 60) begin
            b_rstart();
            send_byte(dev(1'b0, 1'b0), ack);
            n++;
        end
        b_stop();
    endtask

    function automatic logic [7:0] pat(input int seed, input int i);
        return 8'((seed * 29 + i * 37 + 11) & 255);
    endfunction

    // write n bytes from a, data pattern pat(seed,i); model updated; busy polled after
    task automatic wr_seq(input logic pg, input logic [7:0] a, input int n, input int seed);
        logic ack;
        logic [7:0] p;
        int np;
        p = a;
        b_start();
        send_byte(dev(pg, 1'b0), ack); chk("R1 write device ack", {7'd0, ack}, 8'd1);
        send_byte(a, ack);             chk("R2 pointer ack", {7'd0, ack}, 8'd1);
        for (int i = 0; i < n; i++) begin
            send_byte(pat(seed, i), ack);
            chk("R2 data ack", {7'd0, ack}, 8'd1);
            exp_mem[{pg, p}] = pat(seed, i);
            p = p + 8'd1;
        end
        b_stop();
        poll(8'h00, np);
        chk("R5 first poll declined", {7'd0, np > 1}, 8'd1);
        chk("R5 busy ends", {7'd0, np < 60}, 8'd1);
    endtask

    task automatic rd_seq(input logic pg, input logic [7:0] a, input int n, input string req);
        logic ack;
        logic [7:0] b;
        logic [7:0] p;
        p = a;
        b_start();
        send_byte(dev(pg, 1'b0), ack);
        send_byte(a, ack);
        b_rstart();
        send_byte(dev(pg, 1'b1), ack); chk("R4 read device ack", {7'd0, ack}, 8'd1);
        for (int i = 0; i < n; i++) begin
            recv_byte(b, i != n - 1);
            chk(req, b, exp_mem[{pg, p}]);
            p = p + 8'd1;
        end
        b_stop();
    endtask

    // single read at pointer a; port value pa during read device byte, pb during data byte
    task automatic rd1(input logic pg, input logic [7:0] a, input logic [7:0] pa,
                       input logic [7:0] pb, output logic [7:0] b);
        logic ack;
        b_start();
        send_byte(dev(pg, 1'b0), ack);
        send_byte(a, ack);
        b_rstart();
        port_v = pa;
        send_byte(dev(pg, 1'b1), ack);
        port_v = pb;
        recv_byte(b, 1'b0);
        b_stop();
    endtask

    task automatic finish_run();
        if (r10_bad != 0) begin
            n_bad++;
            $display("FAIL R10: %0d enable changes with SCL high, expected 0", r10_bad);
        end
        n_chk++;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic ack;
        logic [7:0] b;
        int np;

        tick(5);
        chk("R10 enable off in reset", {7'd0, sda_oe}, 8'd0);
        rst_n = 1'b1;
        tick(5);

        // R6: mode byte resets to zero
        rd1(1'b0, 8'h7A, 8'h00, 8'h00, b);
        chk("R6 mode reset value", b, 8'h00);

        // R1: sweep of all 7-bit device addresses, write direction
        for (int a = 0; a < 128; a++) begin
            b_start();
            send_byte({7'(a), 1'b0}, ack);
            b_stop();
            chk("R1 device match", {7'd0, ack}, {7'd0, (a[6:1] == DEV)});
        end

        // R2/R3: wrapping writes into both halves at the same pointers
        wr_seq(1'b0, 8'hF0, 20, 1);
        wr_seq(1'b1, 8'hF0, 20, 2);
        rd_seq(1'b0, 8'hF0, 20, "R2 lower-half readback with wrap");
        rd_seq(1'b1, 8'hF0, 20, "R3 upper-half independent data");
        wr_seq(1'b1, 8'h40, 3, 3);
        rd_seq(1'b1, 8'h40, 3, "R3 upper-half second block");
        rd_seq(1'b0, 8'hF5, 4, "R3 lower half untouched");

        // R4: after a NACK the slave stays silent through extra clocks
        b_start();
        send_byte(dev(1'b0, 1'b0), ack);
        send_byte(8'hF0, ack);
        b_rstart();
        send_byte(dev(1'b0, 1'b1), ack);
        recv_byte(b, 1'b0);
        chk("R4 single byte", b, exp_mem[{1'b0, 8'hF0}]);
        for (int i = 0; i < 9; i++) begin
            tick(H); scl_m = 1'b1; tick(H / 2);
            chk("R4 released after NACK", {7'd0, sda_oe}, 8'd0);
            tick(H - H / 2); scl_m = 1'b0; tick(2);
        end
        b_stop();

        // R6: mode byte write and readback, upper 7Ah ordinary
        b_start(); send_byte(dev(1'b0, 1'b0), ack); send_byte(8'h7A, ack);
        send_byte(8'h40, ack); b_stop(); poll(8'h00, np);
        chk("R5 mode write starts busy", {7'd0, np > 1}, 8'd1);
        wr_seq(1'b1, 8'h7A, 1, 9);
        rd1(1'b0, 8'h7A, 8'h00, 8'h00, b);
        chk("R6 mode readback", b, 8'h40);
        rd1(1'b1, 8'h7A, 8'h00, 8'h00, b);
        chk("R6 upper 7Ah is memory", b, exp_mem[{1'b1, 8'h7A}]);

        // R7: port byte carries the sample from the preceding byte
        b_start(); send_byte(dev(1'b0, 1'b0), ack); send_byte(8'h7A, ack);
        b_rstart();
        port_v = 8'hA0; send_byte(dev(1'b0, 1'b1), ack);
        port_v = 8'hB1; recv_byte(b, 1'b1);
        chk("R7 mode byte before port", b, 8'h40);
        port_v = 8'hC9; recv_byte(b, 1'b0);
        chk("R7 port after 7Ah", b, 8'hB1);
        b_stop();
        rd1(1'b0, 8'h7B, 8'hC2, 8'h3D, b);
        chk("R7 port from device byte", b, 8'hC2);

        // R8: direct port mode
        b_start(); send_byte(dev(1'b0, 1'b0), ack); send_byte(8'h7A, ack);
        send_byte(8'h80, ack); b_stop();
        poll(8'hD3, np);
        b_start();
        port_v = 8'hE4; send_byte(dev(1'b0, 1'b1), ack);
        port_v = 8'hF5; recv_byte(b, 1'b1);
        chk("R8 first byte from previous device byte", b, 8'hD3);
        port_v = 8'h06; recv_byte(b, 1'b1);
        chk("R8 second byte", b, 8'hF5);
        port_v = 8'h17; recv_byte(b, 1'b0);
        chk("R8 third byte", b, 8'h06);
        b_stop();
        b_start();
        port_v = 8'h28; send_byte(dev(1'b0, 1'b1), ack);
        port_v = 8'h39; recv_byte(b, 1'b0);
        b_stop();
        chk("R8 first byte of next read", b, 8'hE4);
        b_start(); send_byte(dev(1'b0, 1'b0), ack); send_byte(8'h7A, ack);
        send_byte(8'h00, ack); b_stop(); poll(8'h00, np);

        // R9: START and STOP in the middle of a byte
        b_start(); send_bits(dev(1'b0, 1'b0), 4);
        b_rstart(); send_byte(dev(1'b0, 1'b0), ack);
        chk("R9 restart mid-byte", {7'd0, ack}, 8'd1);
        send_byte(8'h10, ack);
        b_stop();
        b_start(); send_byte(dev(1'b0, 1'b0), ack);
        chk("R5 pointer-only write leaves no busy", {7'd0, ack}, 8'd1);
        send_bits(8'hFF, 3);
        b_stop();
        b_start(); send_byte(dev(1'b1, 1'b0), ack);
        chk("R9 stop mid-byte then new access", {7'd0, ack}, 8'd1);
        b_stop();

        // R5: bytes sent while busy are ignored
        b_start(); send_byte(dev(1'b0, 1'b0), ack); send_byte(8'h20, ack);
        send_byte(8'h11, ack); b_stop();
        exp_mem[{1'b0, 8'h20}] = 8'h11;
        b_start(); send_byte(dev(1'b0, 1'b0), ack);
        chk("R5 declined while busy", {7'd0, ack}, 8'd0);
        send_byte(8'h20, ack); send_byte(8'h99, ack);
        b_stop();
        poll(8'h00, np);
        rd_seq(1'b0, 8'h20, 1, "R5 busy write ignored");

        tick(20);
        finish_run();
    end
endmodule